// File: doc/BRIEF.md
# Page-Crossing Buffer DMA Splitter

This block converts one transfer request into the short series of memory accesses needed to carry it out. For a data buffer, it receives a start pointer, an end pointer, a byte count and a direction. A buffer may run across one 4 KB page boundary, and the page that follows is not assumed to be the next page in memory. The block therefore issues at most two bursts. The first burst begins at the start pointer and stops at the end of that page. The second burst begins at the base of the page that holds the end pointer.

The same engine can also walk a descriptor structure word by word. A plain descriptor takes four 32-bit accesses. An isochronous descriptor takes four 32-bit accesses followed by eight 16-bit accesses. Byte lanes are mapped little-endian. A local-memory base is added to every address the block sends out.

The memory port uses a request/acknowledge handshake. The block presents one access at a time and holds it until it is acknowledged. It gives a one-cycle done pulse when the whole request has finished.

Top module: `pgx_dma_split`

## Requirements
- R1: For a buffer request (`req_op`=0), the first burst address is `req_start` and its length is 0x1000 minus the low 12 bits of `req_start`, limited to `req_len`.
- R2: When the first burst already covers `req_len`, including a buffer that ends exactly at a page end, only one burst is issued.
- R3: Otherwise a second burst follows. Its address is `req_end` with the low 12 bits cleared, and its length is `req_len` minus the first burst length.
- R4: Every `mem_addr` equals the computed address plus the `local_base` value sampled when the request was accepted.
- R5: `mem_wr` equals `req_write` for every access of a request, and the split is the same in both directions.
- R6: A buffer request with `req_len`=0 issues no access and pulses `done` in the cycle after acceptance. Every access that is issued has a nonzero length.
- R7: `done` is high for exactly one cycle, in the cycle after the last access is acknowledged. `done` is low while reset is applied.
- R8: While `mem_req` is high and `mem_ack` is low, `mem_addr`, `mem_len`, `mem_wr` and `mem_be` hold their values.
- R9: A request raised while `busy` is high is ignored: it adds no access and changes no access already under way.
- R10: A plain descriptor (`req_op`=1) issues four 4-byte accesses at `req_start`+0, +4, +8 and +12, each with `mem_be`=1111.
- R11: An isochronous descriptor (`req_op`=2) issues four 4-byte accesses at `req_start`+0 to +12, then eight 2-byte accesses at `req_start`+16+2k. Each 2-byte access has `mem_be`=0011 when address bit 1 is 0 and 1100 when it is 1.
- R12: A reserved kind (`req_op`=3) issues no access and pulses `done` in the cycle after acceptance.
- R13: No buffer burst crosses a 4 KB page boundary: low 12 bits of the address plus the length never exceed 0x1000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe; accepted only while not busy |
| req_op | input | 2 | 0 buffer, 1 plain descriptor, 2 isochronous descriptor, 3 reserved |
| req_start | input | 32 | Start pointer (buffer) or descriptor address |
| req_end | input | 32 | End pointer; its page base seeds the second burst |
| req_len | input | 14 | Buffer byte count (received count for writes) |
| req_write | input | 1 | 1 writes memory, 0 reads memory |
| local_base | input | 32 | Offset added to every outgoing address |
| mem_ack | input | 1 | Memory accepts the current access |
| busy | output | 1 | A request is being processed |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Access valid |
| mem_addr | output | 32 | Access byte address, base included |
| mem_len | output | 14 | Access length in bytes |
| mem_wr | output | 1 | Access direction |
| mem_be | output | 4 | Little-endian byte lanes of the access |

## Verification
Assertions run on every cycle. They check that a stalled access holds steady, that `done` is a single pulse that follows the acknowledgement of the last access, that a request raised while busy leaves the latched request untouched, that no buffer burst spans a page boundary, and that no access has zero length. The directed scenarios are needed for the values themselves. They cover the first and second burst addresses and lengths, the jump to the end pointer's page, the addition of the base, the descriptor address sequences and their lane masks, and the count of accesses for zero-length and reserved requests.

// File: rtl/pgx_pkg.sv
package pgx_pkg;

    parameter int unsigned PGX_ADDR_W = 32;
    parameter int unsigned PGX_LEN_W  = 14;
    parameter int unsigned PGX_PAGE_W = 12;
    parameter int unsigned PGX_BE_W   = 4;
    parameter int unsigned PGX_WORD_B = 4;
    parameter int unsigned PGX_HALF_B = 2;
    localparam int unsigned PGX_PAGE_SZ = 1 << PGX_PAGE_W;

    typedef enum logic [1:0] {
        PGX_OP_BUF  = 2'd0,
        PGX_OP_DESC = 2'd1,
        PGX_OP_ISO  = 2'd2,
        PGX_OP_NONE = 2'd3
    } pgx_op_e;

    typedef enum logic [1:0] {
        PGX_ST_IDLE = 2'd0,
        PGX_ST_RUN  = 2'd1,
        PGX_ST_FIN  = 2'd2
    } pgx_state_e;

    typedef struct packed {
        logic [PGX_ADDR_W-1:0] addr;
        logic [PGX_LEN_W-1:0]  len;
    } pgx_item_t;

    // bytes left in the page from a given offset
    function automatic logic [PGX_LEN_W-1:0] pgx_page_room(input logic [PGX_PAGE_W-1:0] off);
        return PGX_LEN_W'(PGX_PAGE_SZ) - PGX_LEN_W'(off);
    endfunction

    // address with its in-page offset cleared
    function automatic logic [PGX_ADDR_W-1:0] pgx_page_floor(input logic [PGX_ADDR_W-1:0] a);
        return a & ~PGX_ADDR_W'(PGX_PAGE_SZ - 1);
    endfunction

    // little-endian lane select: a halfword at address bit1=0 uses lanes 1:0
    function automatic logic [PGX_BE_W-1:0] pgx_lane_mask(input logic a1,
                                                          input logic [PGX_LEN_W-1:0] len);
        logic [PGX_BE_W-1:0] m;
        if (len == PGX_LEN_W'(PGX_HALF_B))
            m = a1 ? 4'b1100 : 4'b0011;
        else
            m = '1;
        return m;
    endfunction

endpackage

// File: rtl/pgx_split.sv
module pgx_split
    import pgx_pkg::*;
(
    input  logic [PGX_ADDR_W-1:0] start_ptr,
    input  logic [PGX_ADDR_W-1:0] end_ptr,
    input  logic [PGX_LEN_W-1:0]  total_len,
    output pgx_item_t             first_o,
    output pgx_item_t             second_o,
    output logic                  two_o
);
    logic [PGX_LEN_W-1:0] room;

    always_comb begin
        room          = pgx_page_room(start_ptr[PGX_PAGE_W-1:0]);
        two_o         = total_len > room;
        first_o.addr  = start_ptr;
        first_o.len   = two_o ? room : total_len;
        // the continuation restarts at the end pointer's page, not linearly
        second_o.addr = pgx_page_floor(end_ptr);
        second_o.len  = two_o ? (total_len - room) : '0;
    end
endmodule

// File: rtl/pgx_desc_seq.sv
module pgx_desc_seq
    import pgx_pkg::*;
#(
    parameter int unsigned WORDS  = 4,
    parameter int unsigned HALVES = 8,
    parameter int unsigned IDX_W  = 4
)(
    input  pgx_op_e               op,
    input  logic [PGX_ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]      idx,
    output pgx_item_t             item_o,
    output logic                  last_o
);
    localparam int unsigned HALF_OFS = WORDS * PGX_WORD_B;
    localparam int unsigned ISO_LAST = WORDS + HALVES - 1;

    logic in_halves;

    generate
        if (HALVES == 0) begin : g_no_halves
            assign in_halves = 1'b0;
        end else begin : g_halves
            assign in_halves = (op == PGX_OP_ISO) && (idx >= IDX_W'(WORDS));
        end
    endgenerate

    always_comb begin
        if (in_halves) begin
            item_o.addr = base + PGX_ADDR_W'(HALF_OFS)
                        + PGX_ADDR_W'(idx - IDX_W'(WORDS)) * PGX_ADDR_W'(PGX_HALF_B);
            item_o.len  = PGX_LEN_W'(PGX_HALF_B);
        end else begin
            item_o.addr = base + PGX_ADDR_W'(idx) * PGX_ADDR_W'(PGX_WORD_B);
            item_o.len  = PGX_LEN_W'(PGX_WORD_B);
        end
        if (op == PGX_OP_ISO)
            last_o = (idx == IDX_W'(ISO_LAST));
        else
            last_o = (idx == IDX_W'(WORDS - 1));
    end
endmodule

// File: rtl/pgx_ctrl.sv
module pgx_ctrl
    import pgx_pkg::*;
#(
    parameter int unsigned IDX_W = 4
)(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  pgx_op_e               req_op,
    input  logic [PGX_ADDR_W-1:0] req_start,
    input  logic [PGX_ADDR_W-1:0] req_end,
    input  logic [PGX_LEN_W-1:0]  req_len,
    input  logic                  req_write,
    input  logic [PGX_ADDR_W-1:0] local_base,
    input  logic                  mem_ack,
    input  pgx_item_t             first_i,
    input  pgx_item_t             second_i,
    input  logic                  two_i,
    input  pgx_item_t             desc_item_i,
    input  logic                  desc_last_i,
    output pgx_op_e               op_o,
    output logic [PGX_ADDR_W-1:0] start_o,
    output logic [PGX_ADDR_W-1:0] end_o,
    output logic [PGX_LEN_W-1:0]  len_o,
    output logic [PGX_ADDR_W-1:0] base_o,
    output logic [IDX_W-1:0]      idx_o,
    output pgx_item_t             item_o,
    output logic                  wr_o,
    output logic                  busy_o,
    output logic                  done_o,
    output logic                  req_o
);
    pgx_state_e state;
    logic       accept;
    logic       cur_last;
    logic       no_access;

    assign accept    = (state == PGX_ST_IDLE) && req_valid;
    assign no_access = (req_op == PGX_OP_NONE) ||
                       ((req_op == PGX_OP_BUF) && (req_len == '0));

    always_comb begin
        if (op_o == PGX_OP_BUF) begin
            item_o   = (idx_o == '0) ? first_i : second_i;
            cur_last = (idx_o != '0) || !two_i;
        end else begin
            item_o   = desc_item_i;
            cur_last = desc_last_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= PGX_ST_IDLE;
            op_o    <= PGX_OP_NONE;
            start_o <= '0;
            end_o   <= '0;
            len_o   <= '0;
            base_o  <= '0;
            wr_o    <= 1'b0;
            idx_o   <= '0;
        end else begin
            unique case (state)
                PGX_ST_IDLE: if (accept) begin
                    op_o    <= req_op;
                    start_o <= req_start;
                    end_o   <= req_end;
                    len_o   <= req_len;
                    base_o  <= local_base;
                    wr_o    <= req_write;
                    idx_o   <= '0;
                    state   <= no_access ? PGX_ST_FIN : PGX_ST_RUN;
                end
                PGX_ST_RUN: if (mem_ack) begin
                    if (cur_last) state <= PGX_ST_FIN;
                    else          idx_o <= idx_o + 1'b1;
                end
                PGX_ST_FIN: state <= PGX_ST_IDLE;
                default:    state <= PGX_ST_IDLE;
            endcase
        end
    end

    assign busy_o = (state != PGX_ST_IDLE);
    assign done_o = (state == PGX_ST_FIN);
    assign req_o  = (state == PGX_ST_RUN);

    // R8: a waiting access keeps its content
    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (req_o && !mem_ack) |=> (req_o && $stable(item_o) && $stable(wr_o)));

    // R7: completion follows the last acknowledge by one cycle
    assert_done_after_last_R7: assert property (@(posedge clk) disable iff (rst)
        (req_o && mem_ack && cur_last) |=> done_o);

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R9: a strobe while busy leaves the latched request alone
    assert_ignore_busy_R9: assert property (@(posedge clk) disable iff (rst)
        (busy_o && req_valid) |=> ($stable(start_o) && $stable(len_o) && $stable(op_o)));
endmodule

// File: rtl/pgx_dma_split.sv
module pgx_dma_split
    import pgx_pkg::*;
#(
    parameter int unsigned DESC_WORDS = 4,
    parameter int unsigned ISO_HALVES = 8
)(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic [1:0]            req_op,
    input  logic [PGX_ADDR_W-1:0] req_start,
    input  logic [PGX_ADDR_W-1:0] req_end,
    input  logic [PGX_LEN_W-1:0]  req_len,
    input  logic                  req_write,
    input  logic [PGX_ADDR_W-1:0] local_base,
    input  logic                  mem_ack,
    output logic                  busy,
    output logic                  done,
    output logic                  mem_req,
    output logic [PGX_ADDR_W-1:0] mem_addr,
    output logic [PGX_LEN_W-1:0]  mem_len,
    output logic                  mem_wr,
    output logic [PGX_BE_W-1:0]   mem_be
);
    localparam int unsigned SEQ_LEN = DESC_WORDS + ISO_HALVES;
    localparam int unsigned IDX_W   = $clog2(SEQ_LEN + 1);

    pgx_op_e               op_q;
    logic [PGX_ADDR_W-1:0] start_q, end_q, base_q;
    logic [PGX_LEN_W-1:0]  len_q;
    logic [IDX_W-1:0]      idx_q;
    pgx_item_t             first_b, second_b, desc_item, cur_item;
    logic                  two_b, desc_last;

    pgx_split u_split (
        .start_ptr (start_q),
        .end_ptr   (end_q),
        .total_len (len_q),
        .first_o   (first_b),
        .second_o  (second_b),
        .two_o     (two_b)
    );

    pgx_desc_seq #(
        .WORDS  (DESC_WORDS),
        .HALVES (ISO_HALVES),
        .IDX_W  (IDX_W)
    ) u_desc (
        .op     (op_q),
        .base   (start_q),
        .idx    (idx_q),
        .item_o (desc_item),
        .last_o (desc_last)
    );

    pgx_ctrl #(.IDX_W(IDX_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_op      (pgx_op_e'(req_op)),
        .req_start   (req_start),
        .req_end     (req_end),
        .req_len     (req_len),
        .req_write   (req_write),
        .local_base  (local_base),
        .mem_ack     (mem_ack),
        .first_i     (first_b),
        .second_i    (second_b),
        .two_i       (two_b),
        .desc_item_i (desc_item),
        .desc_last_i (desc_last),
        .op_o        (op_q),
        .start_o     (start_q),
        .end_o       (end_q),
        .len_o       (len_q),
        .base_o      (base_q),
        .idx_o       (idx_q),
        .item_o      (cur_item),
        .wr_o        (mem_wr),
        .busy_o      (busy),
        .done_o      (done),
        .req_o       (mem_req)
    );

    assign mem_addr = cur_item.addr + base_q;
    assign mem_len  = cur_item.len;
    assign mem_be   = pgx_lane_mask(mem_addr[1], cur_item.len);

    // R13: a buffer burst stays inside one page
    assert_in_page_R13: assert property (@(posedge clk) disable iff (rst)
        (mem_req && op_q == PGX_OP_BUF) |->
        ((PGX_LEN_W'(cur_item.addr[PGX_PAGE_W-1:0]) + cur_item.len) <= PGX_LEN_W'(PGX_PAGE_SZ)));

    // R6: no empty access ever reaches memory
    assert_nonzero_R6: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_len != '0));
endmodule

// File: tb/sim_pgx_dma_split.sv
module sim_pgx_dma_split;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [31:0] req_start = '0, req_end = '0, local_base = '0;
    logic [13:0] req_len = '0;
    logic        req_write = 1'b0;
    logic        mem_ack = 1'b0;
    logic        busy, done, mem_req, mem_wr;
    logic [31:0] mem_addr;
    logic [13:0] mem_len;
    logic [3:0]  mem_be;

    always #(CLK_NS/2) clk = ~clk;

    pgx_dma_split u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_start(req_start), .req_end(req_end), .req_len(req_len),
        .req_write(req_write), .local_base(local_base), .mem_ack(mem_ack),
        .busy(busy), .done(done), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_len(mem_len), .mem_wr(mem_wr), .mem_be(mem_be)
    );

    int n_chk = 0, n_bad = 0;
    logic [31:0] g_addr [0:15];
    logic [13:0] g_len  [0:15];
    logic        g_wr   [0:15];
    logic [3:0]  g_be   [0:15];
    int n_items, gap, unstable, done_wide, after_busy, finished;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive one request, act as the memory, record every access
    task automatic run_op(input logic [1:0] op, input logic [31:0] s, input logic [31:0] e,
                          input logic [13:0] l, input logic w, input logic [31:0] base,
                          input int delay, input bit spam);
        int since, stall;
        bit spammed;
        n_items = 0; unstable = 0; gap = -1; done_wide = 0; after_busy = 0;
        finished = 0; stall = 0; since = 0; spammed = 0;
        @(negedge clk);
        req_op = op; req_start = s; req_end = e; req_len = l;
        req_write = w; local_base = base; req_valid = 1'b1;
        for (int cyc = 0; cyc < 300 && finished == 0; cyc++) begin
            @(negedge clk);
            req_valid = 1'b0; mem_ack = 1'b0; since++;
            if (done) begin
                gap = since; finished = 1;
            end else if (mem_req && n_items < 16) begin
                if (spam && !spammed) begin
                    spammed = 1; req_valid = 1'b1; req_op = 2'd0;
                    req_start = 32'h00FF_0000; req_len = 14'h40; local_base = 32'h0;
                end
                if (stall == 0) begin
                    g_addr[n_items] = mem_addr; g_len[n_items] = mem_len;
                    g_wr[n_items] = mem_wr;     g_be[n_items] = mem_be;
                end else if (mem_addr !== g_addr[n_items] || mem_len !== g_len[n_items] ||
                             mem_wr !== g_wr[n_items] || mem_be !== g_be[n_items]) begin
                    unstable++;
                end
                if (stall >= delay) begin
                    mem_ack = 1'b1; n_items++; stall = 0; since = 0;
                end else begin
                    stall++;
                end
            end
        end
        if (finished == 0) chk("R7 completion seen", 32'd0, 32'd1);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (k == 0 && done) done_wide = 1;
            if (mem_req || busy) after_busy++;
        end
    endtask

    task automatic t_reset;
        chk("R7 done low in reset", {31'd0, done}, 32'd0);
        chk("R7 busy low in reset", {31'd0, busy}, 32'd0);
        chk("R6 no access in reset", {31'd0, mem_req}, 32'd0);
    endtask

    task automatic t_single;
        run_op(2'd0, 32'h0000_1100, 32'h0000_117F, 14'h80, 1'b0, 32'h0, 0, 0);
        chk("R2 one burst", n_items, 1);
        chk("R1 first addr", g_addr[0], 32'h0000_1100);
        chk("R1 first len", {18'd0, g_len[0]}, 32'h80);
        chk("R7 done one cycle after ack", gap, 1);
        chk("R7 done single pulse", done_wide, 0);
    endtask

    task automatic t_exact_fit;
        run_op(2'd0, 32'h0000_2F00, 32'h0000_2FFF, 14'h100, 1'b0, 32'h0, 0, 0);
        chk("R2 exact page end one burst", n_items, 1);
        chk("R1 exact fit len", {18'd0, g_len[0]}, 32'h100);
    endtask

    task automatic t_cross_write;
        run_op(2'd0, 32'h0000_3F80, 32'h0000_707F, 14'h100, 1'b1, 32'h4000_0000, 0, 0);
        chk("R3 two bursts", n_items, 2);
        chk("R4 first addr with base", g_addr[0], 32'h4000_3F80);
        chk("R1 first len clipped at page", {18'd0, g_len[0]}, 32'h80);
        chk("R13 first ends at page end", (g_addr[0] & 32'hFFF) + g_len[0], 32'h1000);
        chk("R3 second at end page base", g_addr[1], 32'h4000_7000);
        chk("R3 second len remainder", {18'd0, g_len[1]}, 32'h80);
        chk("R5 write flag first", {31'd0, g_wr[0]}, 32'd1);
        chk("R5 write flag second", {31'd0, g_wr[1]}, 32'd1);
    endtask

    task automatic t_cross_stall;
        run_op(2'd0, 32'h0000_5FFC, 32'h0000_9FFF, 14'h1004, 1'b0, 32'h0, 3, 0);
        chk("R3 two bursts read", n_items, 2);
        chk("R1 four byte head", {18'd0, g_len[0]}, 32'h4);
        chk("R3 second addr read", g_addr[1], 32'h0000_9000);
        chk("R3 full page tail", {18'd0, g_len[1]}, 32'h1000);
        chk("R5 read flag", {31'd0, g_wr[1]}, 32'd0);
        chk("R8 held while stalled", unstable, 0);
        chk("R7 done after stalled ack", gap, 1);
    endtask

    task automatic t_zero;
        run_op(2'd0, 32'h0000_0100, 32'h0000_0100, 14'h0, 1'b1, 32'h0, 0, 0);
        chk("R6 zero length no access", n_items, 0);
        chk("R6 done right after accept", gap, 1);
    endtask

    task automatic t_desc;
        run_op(2'd1, 32'h0000_0800, 32'h0, 14'h0, 1'b0, 32'h100, 0, 0);
        chk("R10 four accesses", n_items, 4);
        for (int k = 0; k < 4; k++) begin
            chk("R10 word addr", g_addr[k], 32'h0000_0900 + 32'(k * 4));
            chk("R10 word len", {18'd0, g_len[k]}, 32'd4);
            chk("R10 word lanes", {28'd0, g_be[k]}, 32'hF);
        end
    endtask

    task automatic t_iso;
        run_op(2'd2, 32'h0000_00A0, 32'h0, 14'h0, 1'b1, 32'h0, 1, 0);
        chk("R11 twelve accesses", n_items, 12);
        for (int k = 0; k < 4; k++)
            chk("R11 word addr", g_addr[k], 32'h0000_00A0 + 32'(k * 4));
        for (int k = 0; k < 8; k++) begin
            chk("R11 half addr", g_addr[4 + k], 32'h0000_00B0 + 32'(k * 2));
            chk("R11 half len", {18'd0, g_len[4 + k]}, 32'd2);
            chk("R11 half lanes", {28'd0, g_be[4 + k]}, (k % 2 == 0) ? 32'h3 : 32'hC);
        end
        chk("R5 descriptor write flag", {31'd0, g_wr[11]}, 32'd1);
    endtask

    task automatic t_reserved;
        run_op(2'd3, 32'h0000_1000, 32'h0, 14'h20, 1'b0, 32'h0, 0, 0);
        chk("R12 no access", n_items, 0);
        chk("R12 done after accept", gap, 1);
    endtask

    task automatic t_busy_ignore;
        run_op(2'd0, 32'h0000_1F00, 32'h0000_20FF, 14'h200, 1'b0, 32'h0, 2, 1);
        chk("R9 only own bursts", n_items, 2);
        chk("R9 first unchanged", g_addr[0], 32'h0000_1F00);
        chk("R9 second unchanged", g_addr[1], 32'h0000_2000);
        chk("R9 second len unchanged", {18'd0, g_len[1]}, 32'h100);
        chk("R9 nothing after done", after_busy, 0);
    endtask

    initial begin
        #(CLK_NS * 150000);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_single();
        t_exact_fit();
        t_cross_write();
        t_cross_stall();
        t_zero();
        t_desc();
        t_iso();
        t_reserved();
        t_busy_ignore();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule